// File: doc/BRIEF.md
# Two-Port Semaphore Bank

This block holds a small set of one-bit ownership tokens that two independent agents, called the left and the right port, use to arbitrate for shared resources. Each port asks for a token by writing a 0 to it and gives the token up (or drops an unanswered request) by writing a 1. A port finds out whether it holds a token by reading it back. A read returns 0 to the holder and 1 to everyone else.

When a port asks for a token that the other side holds, the request is not lost. The block remembers it and hands the token over in the same update in which the holder releases it. Reads are captured into a register on each port, so a write from the opposite side in a later cycle cannot disturb a value already returned. The whole bank runs on one clock with an active-low synchronous reset. All strobes and selects are active high.

Top module: `hsem_bank`

## Requirements
- R1: After reset every token is free, and both read-data buses show all ones until the first read.
- R2: A port reaches the tokens only while its select is 1 and its memory enable is 0. With any other combination, that port's write and read strobes have no effect: token state and that port's read data are unchanged.
- R3: The token index is the three lowest address bits. All higher address bits are ignored.
- R4: A write of data bit 0 to a free token gives it to the writer. Afterwards the writer reads 0 and the other port reads 1.
- R5: A write of 0 from a port while the other side holds the token changes no value either port can read. The request is kept pending.
- R6: When the holder writes 1 while the other side has a pending request, ownership passes to the other side in that same update, and its pending request clears.
- R7: When the holder writes 1 and no request is pending, the token becomes free and reads 1 on both ports.
- R8: A port with a pending request that writes 1 withdraws the request. A later release by the holder then frees the token.
- R9: A read strobe captures the token's state from before any write in the same cycle. The value appears on every bit of that port's read data one clock later: 0 if that port holds the token, 1 otherwise. The value holds until the next accepted read.
- R10: If both ports write 0 to the same free token in the same cycle, the left port obtains it and the right port's request becomes pending.
- R11: The tokens are independent. An operation on one token never changes another.
- R12: A write of 1 from a port that neither holds the token nor has a pending request on it has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| lft_sel | input | 1 | Left semaphore select |
| lft_mce | input | 1 | Left memory enable; must be 0 for token access |
| lft_we | input | 1 | Left write strobe |
| lft_re | input | 1 | Left read strobe |
| lft_addr | input | ADDR_W | Left address; low bits pick the token |
| lft_wbit | input | 1 | Left write data bit (0 request, 1 release) |
| lft_rdata | output | DATA_W | Left captured read value, replicated |
| rgt_sel | input | 1 | Right semaphore select |
| rgt_mce | input | 1 | Right memory enable; must be 0 for token access |
| rgt_we | input | 1 | Right write strobe |
| rgt_re | input | 1 | Right read strobe |
| rgt_addr | input | ADDR_W | Right address; low bits pick the token |
| rgt_wbit | input | 1 | Right write data bit (0 request, 1 release) |
| rgt_rdata | output | DATA_W | Right captured read value, replicated |

## Verification
The bench targets the pending-request paths.

- A design that dropped a blocked request would leave the token free after the holder's release, where the other side should own it.
- A design that ignored a withdrawal would grant a token that nobody still wants.

The bench also targets same-cycle cases:

- Simultaneous requests to a free token must go to the left port. A wrong tie-break shows the right port holding it, or both ports reading 0.
- A read issued together with a write must return the pre-write state. A capture taken after the update shows the new owner a cycle early.

Finally, the bench checks that upper address bits and deselected or memory-enabled cycles leave both the tokens and the captured read data alone.

// File: rtl/hsem_pkg.sv
package hsem_pkg;

    typedef enum logic [1:0] {
        TOK_FREE  = 2'b00,
        TOK_LEFT  = 2'b01,
        TOK_RIGHT = 2'b10
    } tok_owner_e;

    typedef struct packed {
        tok_owner_e owner;
        logic       left_wait;
        logic       right_wait;
    } tok_state_t;

    typedef struct packed {
        logic wr_en;
        logic wr_bit;
        logic rd_en;
    } port_cmd_t;

    localparam tok_state_t TOK_RESET = '{owner: TOK_FREE, left_wait: 1'b0, right_wait: 1'b0};

    // One port's write applied to one token state.
    function automatic tok_state_t tok_apply(tok_state_t s, logic from_left, logic wbit);
        tok_state_t n;
        tok_owner_e mine;
        tok_owner_e theirs;
        logic       my_wait;
        logic       their_wait;
        n          = s;
        mine       = from_left ? TOK_LEFT : TOK_RIGHT;
        theirs     = from_left ? TOK_RIGHT : TOK_LEFT;
        my_wait    = from_left ? s.left_wait : s.right_wait;
        their_wait = from_left ? s.right_wait : s.left_wait;
        if (!wbit) begin
            if (s.owner == TOK_FREE) begin
                n.owner = mine;
            end else if (s.owner == theirs) begin
                my_wait = 1'b1;
            end
        end else if (s.owner == mine) begin
            if (their_wait) begin
                n.owner    = theirs;
                their_wait = 1'b0;
            end else begin
                n.owner = TOK_FREE;
            end
        end else begin
            my_wait = 1'b0;
        end
        if (from_left) begin
            n.left_wait  = my_wait;
            n.right_wait = their_wait;
        end else begin
            n.right_wait = my_wait;
            n.left_wait  = their_wait;
        end
        return n;
    endfunction

endpackage

// File: rtl/hsem_port_decode.sv
module hsem_port_decode
    import hsem_pkg::*;
#(
    parameter int ADDR_W = 15,
    parameter int IDX_W  = 3
) (
    input  logic              sel,
    input  logic              mce,
    input  logic              we,
    input  logic              re,
    input  logic [ADDR_W-1:0] addr,
    input  logic              wbit,
    output port_cmd_t         cmd,
    output logic [IDX_W-1:0]  idx
);

    logic access;
    logic unused_hi;

    always_comb begin
        access     = sel && !mce;
        cmd.wr_en  = access && we;
        cmd.rd_en  = access && re;
        cmd.wr_bit = wbit;
        idx        = addr[IDX_W-1:0];
    end

    assign unused_hi = ^addr[ADDR_W-1:IDX_W];

endmodule

// File: rtl/hsem_token.sv
module hsem_token
    import hsem_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       l_wr,
    input  logic       l_bit,
    input  logic       r_wr,
    input  logic       r_bit,
    output tok_state_t st
);

    tok_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (l_wr) st_d = tok_apply(st_d, 1'b1, l_bit);
        if (r_wr) st_d = tok_apply(st_d, 1'b0, r_bit);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= TOK_RESET;
        else        st_q <= st_d;
    end

    assign st = st_q;

    // R5
    left_wait_chk: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.left_wait |-> st_q.owner == TOK_RIGHT);
    // R5
    right_wait_chk: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.right_wait |-> st_q.owner == TOK_LEFT);
    // R6
    handover_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.owner == TOK_LEFT && st_q.right_wait && l_wr && l_bit && !r_wr)
        |=> (st_q.owner == TOK_RIGHT && !st_q.right_wait));
    // R7
    free_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.owner == TOK_LEFT && !st_q.right_wait && l_wr && l_bit && !r_wr)
        |=> st_q.owner == TOK_FREE);
    // R10
    tie_left_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.owner == TOK_FREE && l_wr && !l_bit && r_wr && !r_bit)
        |=> (st_q.owner == TOK_LEFT && st_q.right_wait));
    // R11
    idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!l_wr && !r_wr) |=> $stable(st_q));

endmodule

// File: rtl/hsem_rd_capture.sv
module hsem_rd_capture #(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rd_en,
    input  logic              bit_val,
    output logic [DATA_W-1:0] rdata
);

    typedef struct packed {
        logic [DATA_W-1:0] data;
    } cap_t;

    cap_t cap_d, cap_q;

    always_comb begin
        cap_d = cap_q;
        if (rd_en) cap_d.data = {DATA_W{bit_val}};
    end

    always_ff @(posedge clk) begin
        if (!rst_n) cap_q <= '{data: '1};
        else        cap_q <= cap_d;
    end

    assign rdata = cap_q.data;

    // R9
    cap_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_en |=> $stable(cap_q));
    // R9
    cap_uniform_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cap_q.data == '0) || (cap_q.data == '1));

endmodule

// File: rtl/hsem_bank.sv
module hsem_bank
    import hsem_pkg::*;
#(
    parameter int NUM_TOK = 8,
    parameter int ADDR_W  = 15,
    parameter int DATA_W  = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              lft_sel,
    input  logic              lft_mce,
    input  logic              lft_we,
    input  logic              lft_re,
    input  logic [ADDR_W-1:0] lft_addr,
    input  logic              lft_wbit,
    output logic [DATA_W-1:0] lft_rdata,
    input  logic              rgt_sel,
    input  logic              rgt_mce,
    input  logic              rgt_we,
    input  logic              rgt_re,
    input  logic [ADDR_W-1:0] rgt_addr,
    input  logic              rgt_wbit,
    output logic [DATA_W-1:0] rgt_rdata
);

    localparam int IDX_W = (NUM_TOK > 1) ? $clog2(NUM_TOK) : 1;

    port_cmd_t        l_cmd, r_cmd;
    logic [IDX_W-1:0] l_idx, r_idx;
    logic [NUM_TOK-1:0] lft_view, rgt_view;

    hsem_port_decode #(.ADDR_W(ADDR_W), .IDX_W(IDX_W)) u_dec_l (
        .sel(lft_sel), .mce(lft_mce), .we(lft_we), .re(lft_re),
        .addr(lft_addr), .wbit(lft_wbit), .cmd(l_cmd), .idx(l_idx)
    );

    hsem_port_decode #(.ADDR_W(ADDR_W), .IDX_W(IDX_W)) u_dec_r (
        .sel(rgt_sel), .mce(rgt_mce), .we(rgt_we), .re(rgt_re),
        .addr(rgt_addr), .wbit(rgt_wbit), .cmd(r_cmd), .idx(r_idx)
    );

    for (genvar t = 0; t < NUM_TOK; t++) begin : g_tok
        localparam logic [IDX_W-1:0] TI = IDX_W'(t);
        tok_state_t st;
        logic       l_hit, r_hit;

        assign l_hit = l_cmd.wr_en && (l_idx == TI);
        assign r_hit = r_cmd.wr_en && (r_idx == TI);

        hsem_token u_tok (
            .clk(clk), .rst_n(rst_n),
            .l_wr(l_hit), .l_bit(l_cmd.wr_bit),
            .r_wr(r_hit), .r_bit(r_cmd.wr_bit),
            .st(st)
        );

        assign lft_view[t] = (st.owner != TOK_LEFT);
        assign rgt_view[t] = (st.owner != TOK_RIGHT);
    end

    hsem_rd_capture #(.DATA_W(DATA_W)) u_cap_l (
        .clk(clk), .rst_n(rst_n), .rd_en(l_cmd.rd_en),
        .bit_val(lft_view[l_idx]), .rdata(lft_rdata)
    );

    hsem_rd_capture #(.DATA_W(DATA_W)) u_cap_r (
        .clk(clk), .rst_n(rst_n), .rd_en(r_cmd.rd_en),
        .bit_val(rgt_view[r_idx]), .rdata(rgt_rdata)
    );

    // R4
    excl_owner_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (~lft_view & ~rgt_view) == '0);
    // R2
    lft_ignore_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!lft_sel || lft_mce) |=> $stable(lft_rdata));
    // R2
    rgt_ignore_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!rgt_sel || rgt_mce) |=> $stable(rgt_rdata));

endmodule

// File: tb/hsem_bank_bench.sv
`timescale 1ns/1ps
module hsem_bank_bench;

    localparam int AW = 15;
    localparam int DW = 8;
    localparam int NV = 17;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic l_sel, l_mce, l_we, l_re, l_bit;
    logic r_sel, r_mce, r_we, r_re, r_bit;
    logic [AW-1:0] l_addr, r_addr;
    logic [DW-1:0] l_rd, r_rd;

    int n_chk = 0;
    int n_bad = 0;

    always #4 clk = ~clk;

    hsem_bank #(.NUM_TOK(8), .ADDR_W(AW), .DATA_W(DW)) u_hsem_bank (
        .clk(clk), .rst_n(rst_n),
        .lft_sel(l_sel), .lft_mce(l_mce), .lft_we(l_we), .lft_re(l_re),
        .lft_addr(l_addr), .lft_wbit(l_bit), .lft_rdata(l_rd),
        .rgt_sel(r_sel), .rgt_mce(r_mce), .rgt_we(r_we), .rgt_re(r_re),
        .rgt_addr(r_addr), .rgt_wbit(r_bit), .rgt_rdata(r_rd)
    );

    // Row: lop[14:13] lidx[12:10] rop[9:8] ridx[7:5] chk[4:2] expL[1] expR[0]
    // op: 0 none, 1 request (write 0), 2 release (write 1)
    localparam logic [14:0] VEC [NV] = '{
        {2'd1,3'd2,2'd0,3'd0,3'd2,1'b0,1'b1},  // R4
        {2'd0,3'd0,2'd1,3'd2,3'd2,1'b0,1'b1},  // R5
        {2'd2,3'd2,2'd0,3'd0,3'd2,1'b1,1'b0},  // R6
        {2'd1,3'd2,2'd0,3'd0,3'd2,1'b1,1'b0},  // R5
        {2'd0,3'd0,2'd2,3'd2,3'd2,1'b0,1'b1},  // R6
        {2'd2,3'd2,2'd0,3'd0,3'd2,1'b1,1'b1},  // R7
        {2'd0,3'd0,2'd1,3'd5,3'd5,1'b1,1'b0},  // R4
        {2'd1,3'd5,2'd0,3'd0,3'd5,1'b1,1'b0},  // R5
        {2'd2,3'd5,2'd0,3'd0,3'd5,1'b1,1'b0},  // R8
        {2'd0,3'd0,2'd2,3'd5,3'd5,1'b1,1'b1},  // R8
        {2'd1,3'd3,2'd1,3'd3,3'd3,1'b0,1'b1},  // R10
        {2'd2,3'd3,2'd0,3'd0,3'd3,1'b1,1'b0},  // R10
        {2'd0,3'd0,2'd2,3'd3,3'd3,1'b1,1'b1},  // R7
        {2'd2,3'd6,2'd0,3'd0,3'd6,1'b1,1'b1},  // R12
        {2'd1,3'd0,2'd1,3'd7,3'd0,1'b0,1'b1},  // R11
        {2'd0,3'd0,2'd0,3'd0,3'd7,1'b1,1'b0},  // R11
        {2'd2,3'd0,2'd2,3'd7,3'd0,1'b1,1'b1}   // R11
    };

    task automatic chk(input string req, input logic [DW-1:0] act, input logic [DW-1:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic lset(input logic s, input logic m, input logic w, input logic r,
                        input logic [AW-1:0] a, input logic b);
        l_sel = s; l_mce = m; l_we = w; l_re = r; l_addr = a; l_bit = b;
    endtask

    task automatic rset(input logic s, input logic m, input logic w, input logic r,
                        input logic [AW-1:0] a, input logic b);
        r_sel = s; r_mce = m; r_we = w; r_re = r; r_addr = a; r_bit = b;
    endtask

    task automatic idle();
        lset(1'b0, 1'b0, 1'b0, 1'b0, '0, 1'b0);
        rset(1'b0, 1'b0, 1'b0, 1'b0, '0, 1'b0);
    endtask

    // One active edge, return at the following falling edge with inputs idle.
    task automatic tick();
        @(posedge clk);
        @(negedge clk);
        idle();
    endtask

    task automatic read_both(input logic [AW-1:0] a);
        lset(1'b1, 1'b0, 1'b0, 1'b1, a, 1'b0);
        rset(1'b1, 1'b0, 1'b0, 1'b1, a, 1'b0);
        tick();
    endtask

    task automatic finish_run();
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: actual hung expected done");
        finish_run();
    end

    initial begin
        idle();
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        chk("R1 reset left", l_rd, '1);
        chk("R1 reset right", r_rd, '1);
        read_both(15'd4);
        chk("R1 free after reset left", l_rd, '1);
        chk("R1 free after reset right", r_rd, '1);

        for (int i = 0; i < NV; i++) begin
            logic [14:0] v;
            v = VEC[i];
            lset(v[14:13] != 2'd0, 1'b0, v[14:13] != 2'd0, 1'b0, AW'(v[12:10]), v[14:13] == 2'd2);
            rset(v[9:8] != 2'd0, 1'b0, v[9:8] != 2'd0, 1'b0, AW'(v[7:5]), v[9:8] == 2'd2);
            tick();
            read_both(AW'(v[4:2]));
            chk($sformatf("table row %0d left (R4..R12)", i), l_rd, {DW{v[1]}});
            chk($sformatf("table row %0d right (R4..R12)", i), r_rd, {DW{v[0]}});
        end

        // R2: requests blocked by memory enable high or select low
        lset(1'b1, 1'b1, 1'b1, 1'b0, 15'd1, 1'b0); tick();
        lset(1'b0, 1'b0, 1'b1, 1'b0, 15'd1, 1'b0); tick();
        read_both(15'd1);
        chk("R2 blocked write left", l_rd, '1);
        chk("R2 blocked write right", r_rd, '1);

        // R3: upper address bits ignored
        lset(1'b1, 1'b0, 1'b1, 1'b0, 15'h5A0B, 1'b0); tick();
        lset(1'b1, 1'b0, 1'b0, 1'b1, 15'h7FFB, 1'b0);
        rset(1'b1, 1'b0, 1'b0, 1'b1, 15'h0003, 1'b0);
        tick();
        chk("R3 alias owner left", l_rd, '0);
        chk("R3 alias view right", r_rd, '1);
        lset(1'b1, 1'b0, 1'b1, 1'b0, 15'h100B, 1'b1); tick();
        read_both(15'd3);
        chk("R3 alias release left", l_rd, '1);

        // R9: read concurrent with write sees pre-write state, then holds
        lset(1'b1, 1'b0, 1'b1, 1'b1, 15'd4, 1'b0);
        rset(1'b1, 1'b0, 1'b0, 1'b1, 15'd4, 1'b0);
        tick();
        chk("R9 pre-write capture left", l_rd, '1);
        chk("R9 pre-write capture right", r_rd, '1);
        tick();
        chk("R9 hold with no read", l_rd, '1);
        lset(1'b1, 1'b0, 1'b0, 1'b1, 15'd4, 1'b0); tick();
        chk("R9 owner reads zero", l_rd, '0);
        lset(1'b1, 1'b1, 1'b0, 1'b1, 15'd5, 1'b0); tick();
        chk("R2 read with memory enable ignored", l_rd, '0);
        rset(1'b0, 1'b0, 1'b0, 1'b1, 15'd4, 1'b0); tick();
        chk("R2 read without select ignored", r_rd, '1);

        // R1: reset in the middle of ownership
        lset(1'b1, 1'b0, 1'b1, 1'b0, 15'd6, 1'b0);
        rset(1'b1, 1'b0, 1'b1, 1'b0, 15'd7, 1'b0);
        tick();
        rst_n = 1'b0;
        tick();
        tick();
        rst_n = 1'b1;
        chk("R1 rdata after mid reset", l_rd, '1);
        read_both(15'd4);
        chk("R1 token4 freed left", l_rd, '1);
        read_both(15'd6);
        chk("R1 token6 freed left", l_rd, '1);
        read_both(15'd7);
        chk("R1 token7 freed right", r_rd, '1);

        finish_run();
    end

endmodule